// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus-facing half of a byte-wide serial memory with a 17-bit address space. It oversamples the clock and data lines of a two-wire bus with the system clock, detects Start and Stop, shifts bytes in most significant bit first, and decodes a control byte. That byte carries a device-type code, two chip-select bits, a block bit and a direction bit. In a write, two address bytes follow the control byte. Data bytes are then handed to a separate write engine one at a time. The engine owns the array, the page buffer and the programming delay.

The block keeps the internal address pointer. It drives ACK and read data through an open-drain enable, and it serves current-address, random and sequential reads. While the engine reports busy, the block stays silent on a matching control byte, so the bus master can poll until a programming cycle ends. Sequential reads and writes advance the pointer inside one 64K half of the space. The block bit only selects a half when an address phase loads the pointer.

Top module: `i2c_mem_target`

## Requirements
- R1: With SCL high, an SDA fall is a Start and an SDA rise is a Stop; neither is taken as data. A Start or Stop that arrives part-way through a byte abandons that byte: no write strobe is issued, and after a Start the bit count restarts on a fresh control byte.
- R2: The control byte arrives MSB first. Bits 7..4 must equal the device code 1010, bits 3..2 are chip select (bit 3 compared with strap_cs[1], bit 2 with strap_cs[0]), bit 1 is the block bit and bit 0 is direction (1 = read, 0 = write). Acknowledging means holding sda_oe=1 (SDA low) through the ninth clock.
- R3: A control byte whose code or chip-select bits do not match is not acknowledged, and the block leaves SDA released for every clock until the next Start.
- R4: While busy_i=1, a matching control byte of either direction is not acknowledged. Once busy_i=0 it is acknowledged again.
- R5: After a write control byte, the high address byte (bits 15..8) and then the low address byte (bits 7..0) are each acknowledged. The pointer then becomes {block bit, high, low}.
- R6: Each complete data byte in a write is acknowledged and produces a one-cycle wr_stb carrying wr_addr = pointer and wr_data = the byte. The pointer then advances. After reset, wr_stb is 0.
- R7: A repeated Start after the address bytes, followed by a read control byte, returns the byte at the loaded address.
- R8: A read control byte with no address phase returns the byte at the current pointer, one past the last byte read or written; the block bit of that control byte is ignored. The pointer resets to 0 and is shown on mem_addr.
- R9: In a read, a master ACK (SDA low in the ninth clock) makes the block send the next byte. A master NACK makes it release SDA and stay silent until a Start or Stop.
- R10: Advancing the pointer wraps 0FFFFh to 00000h and 1FFFFh to 10000h; bit 16 never changes by advancing.
- R11: sda_oe is 0 after reset and changes only while SCL is low, a few cycles after a falling SCL edge.
- R12: A Stop after a write in which at least one full data byte was accepted gives a one-cycle wr_commit pulse. An address-only write, a read or an abandoned data byte gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_cs | input | 2 | Chip-select strap levels |
| busy_i | input | 1 | Write engine is programming |
| mem_addr | output | 17 | Current pointer, read address to the array |
| mem_rdata | input | 8 | Byte at mem_addr from the array |
| wr_stb | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 17 | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse: write command ended by Stop |

## Verification
The hardest states to reach are the two pointer wraps and the abandoned byte. Each wrap needs an address phase that lands on the last byte of a half, followed by enough master ACKs or written bytes to step past it. A bus-level master in the bench therefore loads 1FFFEh and 0FFFFh and streams across those boundaries. It checks that bit 16 is kept both in the strobed write addresses and in the returned read data. For the abandoned byte, the master sends only a few bits and then issues a Start or Stop while SCL is low. A later current-address read then shows whether the pointer and the commit count were left untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 17;
   localparam int CS_W   = 2;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CTRL, ST_ADRH, ST_ADRL, ST_WDAT, ST_RDAT, ST_SKIP
   } st_t;

   typedef enum logic [1:0] {
      PH_BITS, PH_ACK, PH_MACK
   } ph_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stg
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= '1;
            else        stg[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= '1;
            else        stg[g] <= stg[g-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2cm_cond.sv
module i2cm_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_ptr.sv
module i2cm_ptr #(
   parameter int AW = 17
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          inc,
   output logic [AW-1:0] ptr
);
   localparam int LOW_W = AW - 1;

   if (AW < 2) begin : g_bad_aw
      $error("i2cm_ptr: AW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   ptr <= '0;
      else if (ld)  ptr <= ld_val;
      else if (inc) ptr <= {ptr[AW-1], ptr[LOW_W-1:0] + 1'b1};

   // R10: advancing never moves the pointer to the other half
   a_r10_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld) |=> ptr[AW-1] == $past(ptr[AW-1]));
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
   import i2cm_pkg::*;
#(
   parameter logic [3:0] DEV_CODE    = 4'b1010,
   parameter int         SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [CS_W-1:0]   strap_cs,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_commit
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (ADDR_W != 1 + 2 * BYTE_W) begin : g_bad_addr
      $error("i2c_mem_target: address must be block bit plus two bytes");
   end
   if (4 + CS_W + 2 != BYTE_W) begin : g_bad_ctrl
      $error("i2c_mem_target: control byte fields must fill one byte");
   end

   logic [1:0] sync_q;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_c, stop_c;

   i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(sync_q));
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   i2cm_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c));

   st_t               st;
   ph_t               ph;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh, tx, hi;
   logic              blk, rd_op, wrote, mack;
   logic              ptr_ld, ptr_inc;
   logic [ADDR_W-1:0] ld_val, ptr_q;
   logic              match, active;

   i2cm_ptr #(.AW(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(ld_val),
      .inc(ptr_inc), .ptr(ptr_q));
   assign mem_addr = ptr_q;

   assign match  = (sh[7:4] == DEV_CODE) && (sh[3:2] == strap_cs);
   assign active = (st != ST_IDLE) && (st != ST_SKIP);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st <= ST_IDLE;  ph <= PH_BITS;  cnt <= '0;
         sh <= '0;  tx <= '0;  hi <= '0;
         blk <= 1'b0;  rd_op <= 1'b0;  wrote <= 1'b0;  mack <= 1'b0;
         ptr_ld <= 1'b0;  ptr_inc <= 1'b0;  ld_val <= '0;
         sda_oe <= 1'b0;  wr_stb <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
         wr_commit <= 1'b0;
      end else begin
         wr_stb    <= 1'b0;
         wr_commit <= 1'b0;
         ptr_ld    <= 1'b0;
         ptr_inc   <= 1'b0;
         if (stop_c) begin
            st <= ST_IDLE;  ph <= PH_BITS;  cnt <= '0;  sda_oe <= 1'b0;
            wr_commit <= wrote;
            wrote     <= 1'b0;
         end else if (start_c) begin
            st <= ST_CTRL;  ph <= PH_BITS;  cnt <= '0;  sda_oe <= 1'b0;
            sh <= '0;
         end else if (active) begin
            case (ph)
               PH_BITS: begin
                  if (scl_rise && cnt < LAST_BIT) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && st == ST_RDAT) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        ph     <= PH_MACK;
                     end else if (cnt != '0) begin
                        sda_oe <= ~tx[BYTE_W-2];
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                     end
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     sda_oe <= 1'b1;
                     ph     <= PH_ACK;
                     case (st)
                        ST_CTRL:
                           if (!match || busy_i) begin
                              sda_oe <= 1'b0;
                              ph     <= PH_BITS;
                              st     <= ST_SKIP;
                           end else begin
                              blk   <= sh[1];
                              rd_op <= sh[0];
                           end
                        ST_ADRH: hi <= sh;
                        ST_ADRL: begin
                           ptr_ld <= 1'b1;
                           ld_val <= {blk, hi, sh};
                        end
                        ST_WDAT: begin
                           wr_stb  <= 1'b1;
                           wr_addr <= ptr_q;
                           wr_data <= sh;
                           ptr_inc <= 1'b1;
                           wrote   <= 1'b1;
                        end
                        default: ;
                     endcase
                  end
               end
               PH_ACK: begin
                  if (scl_fall) begin
                     cnt    <= '0;
                     ph     <= PH_BITS;
                     sda_oe <= 1'b0;
                     case (st)
                        ST_CTRL:
                           if (rd_op) begin
                              st      <= ST_RDAT;
                              tx      <= mem_rdata;
                              sda_oe  <= ~mem_rdata[BYTE_W-1];
                              ptr_inc <= 1'b1;
                           end else begin
                              st <= ST_ADRH;
                           end
                        ST_ADRH: st <= ST_ADRL;
                        ST_ADRL: st <= ST_WDAT;
                        default: ;
                     endcase
                  end
               end
               default: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     ph <= PH_BITS;
                     if (mack) begin
                        cnt     <= '0;
                        tx      <= mem_rdata;
                        sda_oe  <= ~mem_rdata[BYTE_W-1];
                        ptr_inc <= 1'b1;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
            endcase
         end
      end

   // R11: the drive is switched on only while SCL is seen low
   a_r11_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R6: every strobed data byte is acknowledged in the same clock
   a_r6_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sda_oe);

   // R1: a Start releases the line and restarts control decoding
   a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (!sda_oe && st == ST_CTRL));

   // R3: while waiting for a Start after a mismatch the line stays free
   a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !sda_oe);
endmodule

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;
   localparam int Q = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic [1:0]  strap = 2'b10;
   logic        sda_oe, wr_stb, wr_commit;
   logic [16:0] mem_addr, wr_addr;
   logic [7:0]  mem_rdata = 8'h00, wr_data;
   wire         sda_line = sda_m & ~sda_oe;

   int total = 0, bad = 0, n_commit = 0, mptr = 0;
   logic [7:0] store [int];
   logic scl_prev = 1'b1, oe_prev = 1'b0;

   always #2 clk = ~clk;

   i2c_mem_target i_i2c_mem_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap_cs(strap), .busy_i(busy),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_commit(wr_commit));

   function automatic logic [7:0] pat(input int a);
      logic [16:0] v = a[16:0];
      return v[7:0] ^ v[15:8] ^ {7'b0, v[16]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] model_rd(input int a);
      if (store.exists(a)) return store[a];
      return pat(a);
   endfunction

   function automatic int next_ptr(input int a);
      return (a & 32'h10000) | ((a + 1) & 32'hFFFF);
   endfunction

   function automatic logic [7:0] ctrl(input logic b, input logic rw);
      return {4'b1010, strap, b, rw};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference memory, write monitor and line-stability model, every clock
   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         check("R6 write address", int'(wr_addr), mptr);
         store[mptr] = wr_data;
         mptr = next_ptr(mptr);
      end
      if (rst_n && wr_commit) n_commit++;
      if (rst_n && scl_m && scl_prev)
         check("R11 drive stable while SCL high", int'(sda_oe), int'(oe_prev));
      scl_prev  = scl_m;
      oe_prev   = sda_oe;
      mem_rdata = model_rd(int'(mem_addr));
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_start();
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      sda_m = 1'b0; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      sda_m = 1'b1; wt(2*Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      b = sda_line; wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
   endtask

   // returns 1 when the target acknowledged
   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic a;
      send_bits(v, 8);
      get_bit(a);
      acked = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack);
   endtask

   task automatic expect_read(input string req, input logic give_ack);
      logic [7:0] v;
      logic [7:0] e;
      e = model_rd(mptr);
      recv_byte(v, give_ack);
      check(req, int'(v), int'(e));
      mptr = next_ptr(mptr);
   endtask

   initial begin
      logic ak;
      logic b;
      int zeros;
      logic [7:0] v;
      wt(5);
      check("R11 reset drive", int'(sda_oe), 0);
      check("R6 reset strobe", int'(wr_stb), 0);
      check("R8 reset pointer", int'(mem_addr), 0);
      rst_n = 1'b1;
      wt(5);

      // byte/page write at 01234h
      do_start();
      send_byte(ctrl(1'b0, 1'b0), ak); check("R2 matching control ack", int'(ak), 1);
      send_byte(8'h12, ak);            check("R5 high address ack", int'(ak), 1);
      send_byte(8'h34, ak);            check("R5 low address ack", int'(ak), 1);
      mptr = 32'h01234;
      check("R5 pointer loaded", int'(mem_addr), 32'h01234);
      send_byte(8'hA1, ak); check("R6 data ack", int'(ak), 1);
      send_byte(8'hB2, ak); check("R6 data ack", int'(ak), 1);
      send_byte(8'hC3, ak); check("R6 data ack", int'(ak), 1);
      do_stop();
      wt(4);
      check("R12 commit after write", n_commit, 1);

      // random read in upper half across 1FFFFh
      do_start();
      send_byte(ctrl(1'b1, 1'b0), ak); check("R2 block bit control ack", int'(ak), 1);
      send_byte(8'hFF, ak); send_byte(8'hFE, ak);
      mptr = 32'h1FFFE;
      do_start();
      send_byte(ctrl(1'b1, 1'b1), ak); check("R7 read control ack", int'(ak), 1);
      expect_read("R7 random read data", 1'b1);
      expect_read("R9 sequential next byte", 1'b1);
      expect_read("R10 wrap 1FFFFh to 10000h", 1'b0);
      zeros = 0;
      for (int i = 0; i < 8; i++) begin
         get_bit(b);
         if (!b) zeros++;
      end
      check("R9 line released after NACK", zeros, 0);
      do_stop();
      wt(4);
      check("R12 no commit for address-only write", n_commit, 1);

      // current-address read, block bit of control ignored
      do_start();
      send_byte(ctrl(1'b0, 1'b1), ak); check("R8 current read ack", int'(ak), 1);
      expect_read("R8 current address data", 1'b0);
      do_stop();

      // chip select mismatch, then ignored bytes
      do_start();
      send_byte(8'hA4, ak); check("R3 wrong chip select not acked", int'(ak), 0);
      send_byte(ctrl(1'b0, 1'b0), ak); check("R3 silent until Start", int'(ak), 0);
      do_stop();

      // wrong device code
      do_start();
      send_byte(8'hB8, ak); check("R2 wrong device code not acked", int'(ak), 0);
      do_stop();

      // busy polling
      busy = 1'b1;
      do_start();
      send_byte(ctrl(1'b0, 1'b0), ak); check("R4 busy write control not acked", int'(ak), 0);
      do_start();
      send_byte(ctrl(1'b0, 1'b1), ak); check("R4 busy read control not acked", int'(ak), 0);
      do_stop();
      busy = 1'b0;
      do_start();
      send_byte(ctrl(1'b0, 1'b0), ak); check("R4 acked once idle", int'(ak), 1);
      do_stop();
      wt(4);
      check("R12 no commit without data", n_commit, 1);

      // write across 0FFFFh
      do_start();
      send_byte(ctrl(1'b0, 1'b0), ak);
      send_byte(8'hFF, ak); send_byte(8'hFF, ak);
      mptr = 32'h0FFFF;
      send_byte(8'h11, ak); check("R6 data ack at FFFFh", int'(ak), 1);
      send_byte(8'h22, ak); check("R10 write wraps to 00000h", int'(mem_addr), 32'h00001);
      do_stop();
      wt(4);
      check("R12 second commit", n_commit, 2);
      do_start();
      send_byte(ctrl(1'b0, 1'b0), ak);
      send_byte(8'hFF, ak); send_byte(8'hFF, ak);
      mptr = 32'h0FFFF;
      do_start();
      send_byte(ctrl(1'b0, 1'b1), ak);
      recv_byte(v, 1'b1); check("R7 readback at 0FFFFh", int'(v), 8'h11);
      recv_byte(v, 1'b0); check("R10 read wraps to 00000h", int'(v), 8'h22);
      mptr = 32'h00001;
      do_stop();

      // Start in the middle of a control byte
      do_start();
      send_bits(ctrl(1'b0, 1'b1), 4);
      do_start();
      send_byte(ctrl(1'b0, 1'b1), ak); check("R1 control after mid-byte Start acked", int'(ak), 1);
      expect_read("R1 read after restart", 1'b0);
      do_stop();

      // Stop in the middle of a data byte
      do_start();
      send_byte(ctrl(1'b0, 1'b0), ak);
      send_byte(8'h00, ak); send_byte(8'h10, ak);
      mptr = 32'h00010;
      send_bits(8'h55, 3);
      do_stop();
      wt(4);
      check("R1 abandoned byte gives no commit", n_commit, 2);
      do_start();
      send_byte(ctrl(1'b0, 1'b1), ak);
      expect_read("R1 pointer untouched by abandoned byte", 1'b0);
      do_stop();

      wt(10);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule